// File: doc/BRIEF.md
# Sixteen-Bit Add/Subtract Unit with Carry and Overflow Flags

This block is the arithmetic slice of a 16-bit ALU. It is purely combinational. A 3-bit operation code selects one of six operations on two operands: signed or unsigned addition, signed or unsigned subtraction, increment and decrement. All six share one adder. Subtraction feeds the adder the inverted second operand and a forced carry of one. Increment adds the constant one. Decrement adds the all-ones constant.

The block produces three status signals. The carry output passes through an active-low enable. A signed overflow flag is computed from the sign bits. A single ALU overflow flag picks whichever of these conditions matters for the selected operation: signed overflow, unsigned carry, or unsigned borrow. The external carry input takes part only in the two addition codes. The two unused codes produce all-zero outputs.

Top module: `arith_unit16`

## Requirements
- R1: Code 3'b000 (signed add) and code 3'b001 (unsigned add) give C = A + B + cin, modulo 2^16.
- R2: Code 3'b010 (signed subtract) and code 3'b011 (unsigned subtract) give C = A - B, modulo 2^16. The carry input has no effect on these codes.
- R3: Code 3'b100 gives C = A + 1 and code 3'b101 gives C = A - 1, modulo 2^16. The carry input has no effect on either code.
- R4: With coe_n low, cout is the carry out of bit 15 of the adder. For subtraction this is 1 exactly when A >= B as unsigned numbers. For increment it is 1 only when A = 16'hFFFF. For decrement it is 1 whenever A != 0.
- R5: With coe_n high, cout is 0 for every code and every operand value.
- R6: vout is 1 exactly when the mathematically exact signed result of the selected operation lies outside [-32768, 32767]. For the add codes this result includes cin.
- R7: For the signed codes (3'b000, 3'b010, 3'b100, 3'b101), the ALU overflow flag equals vout.
- R8: For code 3'b001, the ALU overflow flag is the carry out of bit 15, and coe_n does not change it.
- R9: For code 3'b011, the ALU overflow flag is 1 exactly when A < B as unsigned numbers (a borrow), and coe_n does not change it.
- R10: Codes 3'b110 and 3'b111 drive C, cout, vout and the ALU overflow flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand A |
| b_i | input | 16 | Second operand B |
| op_i | input | 3 | Operation code |
| cin_i | input | 1 | Carry input, used by the add codes only |
| coe_n_i | input | 1 | Active-low enable for the carry output |
| c_o | output | 16 | Result C |
| cout_o | output | 1 | Gated carry out of bit 15 |
| vout_o | output | 1 | Signed two's-complement overflow |
| ovf_o | output | 1 | ALU overflow flag for the selected operation |

## Verification
A carry out of bit 15 and a signed overflow can occur together on one operation. Examples are 16'h8000 + 16'h8000 under either add code, and 16'h8000 - 16'h0001. Directed vectors provoke both in one evaluation. The bench compares cout, vout and the ALU overflow flag against a model that computes the exact result at wider width, both signed and unsigned. It repeats each vector with coe_n high, so it can confirm that gating the carry output leaves vout and the ALU overflow flag unchanged.

// File: rtl/arith_pkg.sv
package arith_pkg;
   typedef enum logic [2:0] {
      OP_ADD  = 3'b000,
      OP_ADDU = 3'b001,
      OP_SUB  = 3'b010,
      OP_SUBU = 3'b011,
      OP_INC  = 3'b100,
      OP_DEC  = 3'b101,
      OP_RSV6 = 3'b110,
      OP_RSV7 = 3'b111
   } arith_op_e;

   function automatic logic is_signed_op(arith_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
   endfunction
endpackage

// File: rtl/arith_operand_prep.sv
module arith_operand_prep
   import arith_pkg::*;
#(
   parameter int W = 16
) (
   input  arith_op_e      op_i,
   input  logic [W-1:0]   b_i,
   input  logic           cin_i,
   output logic [W-1:0]   b_eff_o,
   output logic           cin_eff_o,
   output logic           valid_o
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] ONES = {W{1'b1}};

   always_comb begin
      b_eff_o   = '0;
      cin_eff_o = 1'b0;
      valid_o   = 1'b1;
      unique case (op_i)
         OP_ADD, OP_ADDU: begin b_eff_o = b_i;  cin_eff_o = cin_i; end
         OP_SUB, OP_SUBU: begin b_eff_o = ~b_i; cin_eff_o = 1'b1;  end
         OP_INC:          begin b_eff_o = ONE;  cin_eff_o = 1'b0;  end
         OP_DEC:          begin b_eff_o = ONES; cin_eff_o = 1'b0;  end
         default:         valid_o = 1'b0;
      endcase
   end

   // R2: the subtract codes always force a carry of one into the adder
   always_comb begin
      if (!$isunknown(op_i) && (op_i == OP_SUB || op_i == OP_SUBU))
         p_sub_carry_r2: assert (cin_eff_o == 1'b1);
   end
endmodule

// File: rtl/arith_add_core.sv
module arith_add_core #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         ci_i,
   output logic [W-1:0] s_o,
   output logic         co_o
);
   if (W < 2) begin : g_bad_width
      $error("arith_add_core: W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [W:0] cy;
      assign cy[0] = ci_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign s_o[i]   = a_i[i] ^ b_i[i] ^ cy[i];
         assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
      end
      assign co_o = cy[W];
   end else begin : g_flat
      logic [W:0] full;
      assign full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci_i};
      assign s_o  = full[W-1:0];
      assign co_o = full[W];
   end
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
   import arith_pkg::*;
(
   input  arith_op_e op_i,
   input  logic      valid_i,
   input  logic      a_msb_i,
   input  logic      b_msb_i,
   input  logic      s_msb_i,
   input  logic      co_i,
   input  logic      coe_n_i,
   output logic      cout_o,
   output logic      vout_o,
   output logic      ovf_o
);
   logic sign_ovf;

   assign sign_ovf = (a_msb_i == b_msb_i) && (s_msb_i != a_msb_i);
   assign vout_o   = valid_i & sign_ovf;
   assign cout_o   = valid_i & ~coe_n_i & co_i;

   always_comb begin
      ovf_o = 1'b0;
      if (valid_i) begin
         if (is_signed_op(op_i))   ovf_o = sign_ovf;
         else if (op_i == OP_ADDU) ovf_o = co_i;
         else if (op_i == OP_SUBU) ovf_o = ~co_i;
      end
   end

   // R10: an invalid code never raises any flag
   always_comb begin
      if (!$isunknown({valid_i, cout_o, vout_o, ovf_o}) && !valid_i)
         p_quiet_rsv_r10: assert ({cout_o, vout_o, ovf_o} == 3'b000);
   end
endmodule

// File: rtl/arith_unit16.sv
module arith_unit16
   import arith_pkg::*;
#(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [15:0] a_i,
   input  logic [15:0] b_i,
   input  logic [2:0]  op_i,
   input  logic        cin_i,
   input  logic        coe_n_i,
   output logic [15:0] c_o,
   output logic        cout_o,
   output logic        vout_o,
   output logic        ovf_o
);
   if (W != 16) begin : g_bad_width
      $error("arith_unit16: port width is fixed at 16");
   end

   localparam int MSB = W - 1;

   arith_op_e  op;
   logic [W-1:0] b_eff, sum;
   logic         cin_eff, carry, valid;

   assign op = arith_op_e'(op_i);

   arith_operand_prep #(.W(W)) u_prep (
      .op_i(op), .b_i(b_i), .cin_i(cin_i),
      .b_eff_o(b_eff), .cin_eff_o(cin_eff), .valid_o(valid)
   );

   arith_add_core #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a_i(a_i), .b_i(b_eff), .ci_i(cin_eff), .s_o(sum), .co_o(carry)
   );

   arith_flag_unit u_flags (
      .op_i(op), .valid_i(valid),
      .a_msb_i(a_i[MSB]), .b_msb_i(b_eff[MSB]), .s_msb_i(sum[MSB]),
      .co_i(carry), .coe_n_i(coe_n_i),
      .cout_o(cout_o), .vout_o(vout_o), .ovf_o(ovf_o)
   );

   assign c_o = valid ? sum : '0;

   always_comb begin
      if (!$isunknown({a_i, b_i, op_i, cin_i, coe_n_i, c_o, cout_o, vout_o, ovf_o})) begin
         if (op_i == 3'b000 || op_i == 3'b001)
            p_add_sum_r1: assert (c_o == 16'(a_i + b_i + {15'd0, cin_i}));
         if (op_i == 3'b010 || op_i == 3'b011)
            p_sub_diff_r2: assert (c_o == 16'(a_i - b_i));
         if (op_i == 3'b100)
            p_inc_r3: assert (c_o == 16'(a_i + 16'd1));
         if (coe_n_i)
            p_cout_gated_r5: assert (cout_o == 1'b0);
         if (op_i == 3'b011)
            p_borrow_r9: assert (ovf_o == (a_i < b_i));
      end
   end
endmodule

// File: tb/test_arith_unit16.sv
module test_arith_unit16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] a, b, c;
   logic [2:0]  op;
   logic        cin, coe_n, cout, vout, ovf;
   int checks = 0, errors = 0;

   arith_unit16 i_arith_unit16 (
      .a_i(a), .b_i(b), .op_i(op), .cin_i(cin), .coe_n_i(coe_n),
      .c_o(c), .cout_o(cout), .vout_o(vout), .ovf_o(ovf)
   );

   task automatic check1(string req, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h (op=%b a=%h b=%h cin=%b coe_n=%b)",
                  req, what, act, exp, op, a, b, cin, coe_n);
      end
   endtask

   // independent model from the requirements
   task automatic apply(logic [2:0] o, logic [15:0] x, logic [15:0] y, logic ci, logic en_n, string req);
      int sa, sb, sres;
      longint ua, ub, ures;
      logic [15:0] ec;
      logic eco, ev, eo, raw;
      @(negedge clk);
      op = o; a = x; b = y; cin = ci; coe_n = en_n;
      sa = int'($signed(x)); sb = int'($signed(y)); ua = longint'(x); ub = longint'(y);
      ec = 16'd0; raw = 1'b0; ev = 1'b0; eo = 1'b0;
      case (o)
         3'b000, 3'b001: begin
            ures = ua + ub + longint'(ci); sres = sa + sb + int'(ci);
            ec = ures[15:0]; raw = ures > 65535;
         end
         3'b010, 3'b011: begin
            ures = ua - ub; sres = sa - sb;
            ec = ures[15:0]; raw = ua >= ub;
         end
         3'b100: begin sres = sa + 1; ec = x + 16'd1; raw = x == 16'hFFFF; end
         3'b101: begin sres = sa - 1; ec = x - 16'd1; raw = x != 16'd0; end
         default: sres = 0;
      endcase
      if (o <= 3'b101) ev = (sres > 32767) || (sres < -32768);
      eco = raw & ~en_n;
      if (o == 3'b001) eo = raw;
      else if (o == 3'b011) eo = ~raw;
      else if (o <= 3'b101) eo = ev;
      #2;
      check1(req, "C", c, ec);
      check1(req, "cout", {15'd0, cout}, {15'd0, eco});
      check1(req, "vout", {15'd0, vout}, {15'd0, ev});
      check1(req, "ovf", {15'd0, ovf}, {15'd0, eo});
   endtask

   task automatic both_en(logic [2:0] o, logic [15:0] x, logic [15:0] y, logic ci, string req);
      apply(o, x, y, ci, 1'b0, req);
      apply(o, x, y, ci, 1'b1, req);
   endtask

   task automatic t_reset_state();
      both_en(3'b000, 16'h0000, 16'h0000, 1'b0, "R1 reset");
   endtask

   task automatic t_add();   // R1 R6 R7 R8
      both_en(3'b000, 16'h1234, 16'h0F0F, 1'b1, "R1");
      both_en(3'b000, 16'h7FFF, 16'h0000, 1'b1, "R6");
      both_en(3'b000, 16'h8000, 16'h8000, 1'b0, "R7");
      both_en(3'b001, 16'hFFFF, 16'h0001, 1'b0, "R8");
      both_en(3'b001, 16'h7FFF, 16'h7FFF, 1'b1, "R8");
      both_en(3'b000, 16'hFFFF, 16'hFFFF, 1'b1, "R6");
   endtask

   task automatic t_sub();   // R2 R4 R9
      both_en(3'b010, 16'h0005, 16'h0007, 1'b0, "R2");
      both_en(3'b010, 16'h0005, 16'h0007, 1'b1, "R2");
      both_en(3'b010, 16'h8000, 16'h0001, 1'b0, "R6");
      both_en(3'b010, 16'h7FFF, 16'hFFFF, 1'b1, "R7");
      both_en(3'b011, 16'h0003, 16'h0009, 1'b1, "R9");
      both_en(3'b011, 16'h0009, 16'h0009, 1'b0, "R4");
      both_en(3'b011, 16'hF000, 16'h0FFF, 1'b0, "R9");
   endtask

   task automatic t_incdec();   // R3 R4
      both_en(3'b100, 16'h7FFF, 16'h1111, 1'b1, "R3");
      both_en(3'b100, 16'hFFFF, 16'h0000, 1'b0, "R4");
      both_en(3'b101, 16'h0000, 16'h0000, 1'b1, "R3");
      both_en(3'b101, 16'h8000, 16'hABCD, 1'b0, "R6");
      both_en(3'b101, 16'h0001, 16'h0000, 1'b0, "R4");
   endtask

   task automatic t_gate();   // R5
      apply(3'b001, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R5");
      apply(3'b011, 16'hFFFF, 16'h0000, 1'b0, 1'b1, "R5");
   endtask

   task automatic t_reserved();   // R10
      both_en(3'b110, 16'hFFFF, 16'hFFFF, 1'b1, "R10");
      both_en(3'b111, 16'h8000, 16'h8000, 1'b1, "R10");
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      a = '0; b = '0; op = '0; cin = 1'b0; coe_n = 1'b1;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_add();
      t_sub();
      t_incdec();
      t_gate();
      t_reserved();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule